// File: doc/BRIEF.md
# Timebase Synchronization Controller

This block is the per-core control and status register that walks a core's timebase through the steps needed to take on a time-of-day value from the chip. Firmware writes control bits into a 64-bit register and then polls it by reading. Each read is also the clock of the machine. It runs two read-count timers, advances the state when a pending request's delay has run out, and returns the updated register. The chip-level time-of-day unit sees `ready_for_tod` and answers with a `tod_sent_pulse`. The core sees `tb_valid` once the machine reaches the running state, and `ctl_error` when firmware broke the protocol.

Bits are numbered MSB-first: bit n of the register sits at vector index 63-n. Bits 0..24 are control bits and bits 25..63 are status bits. The control bits are: 10 interrupt mask, 14 mode enable, 16 load request, 18 transfer request, 24 clear errors. The status bits are: 28..31 current state, 32..35 previous state, 40 enabled, 41 valid, 42 sync seen, 46 control error. The state codes are 0 idle, 1 send-mod, 2 unset, 6 wait-sync, 7 fetch, 8 running, 9 error. The read port is registered, so `rd_data` changes in the cycle after `rd_en`. A write and a read in the same cycle perform only the write.

Top module: `tbsync_ctrl`

## Requirements
- R1: A write with bit 14 set copies bits 0..24 from the write data. A read returns the register with bit 14 forced to 1 one cycle after `rd_en`.
- R2: A write with bit 14 clear zeroes bits 28..35 and changes nothing else.
- R3: Every state change moves the old current state into bits 32..35. Bit 41 and `tb_valid` are set when the new state is running (8) and cleared on any other change.
- R4: A write with bit 14 set clears bit 42 and arms a sync counter to 1. A read decrements a non-zero counter, and a read that finds it zero sets bit 42.
- R5: A write that leaves both bit 16 and bit 18 set enters error (9), sets bit 46 (`ctl_error`) and drops `ready_for_tod`.
- R6: A write with bit 24 set enters idle (0) and clears bits 16, 18, 24, 46, `ready_for_tod` and the captured sent flag.
- R7: A write in error without bit 24 sets bit 46 and leaves the rest of the register unchanged.
- R8: A write with bit 16 arms a 3-read delay. The first read after the delay clears bit 16 and moves to unset (2), with send-mod (1) as the previous state.
- R9: A write with bit 18 in unset moves to wait-sync (6), raises `ready_for_tod` and arms the 3-read delay. Bit 18 written in any other state enters error with bit 46 set.
- R10: After the delay, a read in wait-sync moves to fetch (7) and re-arms the delay. A read in fetch moves to running once the sent flag is set, and clears bit 18, `ready_for_tod` and the flag. A pending bit 16 in fetch enters error with bit 46 set.
- R11: With `is_thread0` low, a write that requests bit 16 or 18 updates the control bits and arms the sync counter, but changes no state and arms no delay.
- R12: `tod_sent_pulse` sets the sticky sent flag only while `ready_for_tod` is high before and after that cycle. A read in the same cycle still uses the flag's previous value.
- R13: Reads change nothing while in error or while the stored bit 14 is clear. When `wr_en` and `rd_en` coincide, only the write is done and `rd_data` holds.
- R14: Synchronous reset zeroes the register, `rd_data`, the flags and both timers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 64 | Write value (bit n at index 63-n) |
| rd_en | input | 1 | Read strobe; advances timers and state |
| rd_data | output | 64 | Value returned by the last read |
| is_thread0 | input | 1 | Access comes from thread 0 |
| tod_sent_pulse | input | 1 | Time-of-day delivered to the core |
| ready_for_tod | output | 1 | Core waits for a time-of-day value |
| tb_valid | output | 1 | Timebase running and valid |
| ctl_error | output | 1 | Firmware control error status |

## Verification
The cycle that matters is the one where a delivery pulse lands together with a read or a write. The bench raises `tod_sent_pulse` with the write that opens the wait, while `ready_for_tod` is still low. It also raises it with a read of the fetch state, and with random writes and reads. The result is judged from the later read at which running is or is not reached. Coincident write and read strobes are also driven, and `rd_data` must hold while the write's effect shows up at the next read.

// File: rtl/tbsync_pkg.sv
package tbsync_pkg;
  localparam int XLEN = 64;
  // MSB-first bit numbers mapped to vector indices
  localparam int B_MASKI  = XLEN - 1 - 10;
  localparam int B_MODE   = XLEN - 1 - 14;
  localparam int B_LOAD   = XLEN - 1 - 16;
  localparam int B_MOVE   = XLEN - 1 - 18;
  localparam int B_CLR    = XLEN - 1 - 24;
  localparam int CUR_HI   = XLEN - 1 - 28;
  localparam int CUR_LO   = XLEN - 1 - 31;
  localparam int PRV_HI   = XLEN - 1 - 32;
  localparam int PRV_LO   = XLEN - 1 - 35;
  localparam int B_ENA    = XLEN - 1 - 40;
  localparam int B_VALID  = XLEN - 1 - 41;
  localparam int B_SYNC   = XLEN - 1 - 42;
  localparam int B_FCE    = XLEN - 1 - 46;
  localparam int CTRL_BITS = 25;
  localparam logic [XLEN-1:0] CTRL_MASK = {{CTRL_BITS{1'b1}}, {(XLEN-CTRL_BITS){1'b0}}};

  typedef enum logic [3:0] {
    ST_IDLE   = 4'd0,
    ST_SEND   = 4'd1,
    ST_UNSET  = 4'd2,
    ST_WSYNC  = 4'd6,
    ST_FETCH  = 4'd7,
    ST_RUN    = 4'd8,
    ST_ERR    = 4'd9
  } tbst_e;

  function automatic logic [XLEN-1:0] go_state(logic [XLEN-1:0] r, tbst_e s);
    logic [XLEN-1:0] t;
    t = r;
    t[PRV_HI:PRV_LO] = r[CUR_HI:CUR_LO];
    t[CUR_HI:CUR_LO] = s;
    t[B_VALID] = (s == ST_RUN);
    return t;
  endfunction
endpackage

// File: rtl/tbsync_wr.sv
module tbsync_wr
  import tbsync_pkg::*;
#(
  parameter int TW = 2,
  parameter int SW = 1,
  parameter int DLY = 3,
  parameter int SYN = 1
) (
  input  logic [XLEN-1:0] cur_reg,
  input  logic            cur_ready,
  input  logic            cur_sent,
  input  logic [TW-1:0]   cur_dly,
  input  logic [SW-1:0]   cur_syn,
  input  logic [XLEN-1:0] wdata,
  input  logic            is_t0,
  output logic [XLEN-1:0] n_reg,
  output logic            n_ready,
  output logic            n_sent,
  output logic [TW-1:0]   n_dly,
  output logic [SW-1:0]   n_syn
);
  logic [XLEN-1:0] t;
  tbst_e st;

  always_comb begin
    st = tbst_e'(cur_reg[CUR_HI:CUR_LO]);
    n_reg = cur_reg;
    n_ready = cur_ready;
    n_sent = cur_sent;
    n_dly = cur_dly;
    n_syn = cur_syn;
    t = (cur_reg & ~CTRL_MASK) | (wdata & CTRL_MASK);
    t[B_FCE] = cur_reg[B_FCE] & ~wdata[B_FCE];
    t[B_SYNC] = 1'b0;
    if (!wdata[B_MODE]) begin
      n_reg[CUR_HI:CUR_LO] = '0;
      n_reg[PRV_HI:PRV_LO] = '0;
    end else if (!is_t0 && (wdata[B_LOAD] || wdata[B_MOVE])) begin
      n_reg = t;
      n_syn = SW'(SYN);
    end else if (t[B_LOAD] && t[B_MOVE]) begin
      n_reg = go_state(t, ST_ERR);
      n_reg[B_FCE] = 1'b1;
      n_ready = 1'b0;
      n_syn = SW'(SYN);
    end else if (t[B_CLR]) begin
      n_reg = go_state(t, ST_IDLE);
      n_reg[B_CLR] = 1'b0;
      n_reg[B_LOAD] = 1'b0;
      n_reg[B_MOVE] = 1'b0;
      n_reg[B_FCE] = 1'b0;
      n_ready = 1'b0;
      n_sent = 1'b0;
      n_syn = SW'(SYN);
    end else if (st == ST_ERR) begin
      n_reg[B_FCE] = 1'b1;
    end else begin
      n_reg = t;
      n_syn = SW'(SYN);
      if (t[B_LOAD]) begin
        n_dly = TW'(DLY);
      end else if (t[B_MOVE]) begin
        if (st == ST_UNSET) begin
          n_reg = go_state(t, ST_WSYNC);
          n_ready = 1'b1;
          n_dly = TW'(DLY);
        end else begin
          n_reg = go_state(t, ST_ERR);
          n_reg[B_FCE] = 1'b1;
          n_ready = 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/tbsync_rd.sv
module tbsync_rd
  import tbsync_pkg::*;
#(
  parameter int TW = 2,
  parameter int SW = 1,
  parameter int DLY = 3
) (
  input  logic [XLEN-1:0] cur_reg,
  input  logic            cur_ready,
  input  logic            cur_sent,
  input  logic [TW-1:0]   cur_dly,
  input  logic [SW-1:0]   cur_syn,
  output logic [XLEN-1:0] n_reg,
  output logic            n_ready,
  output logic            n_sent,
  output logic [TW-1:0]   n_dly,
  output logic [SW-1:0]   n_syn
);
  tbst_e st;

  always_comb begin
    st = tbst_e'(cur_reg[CUR_HI:CUR_LO]);
    n_reg = cur_reg;
    n_ready = cur_ready;
    n_sent = cur_sent;
    n_dly = cur_dly;
    n_syn = cur_syn;
    if (cur_reg[B_MODE] && st != ST_ERR) begin
      if (cur_syn != '0) n_syn = cur_syn - 1'b1;
      else               n_reg[B_SYNC] = 1'b1;
      if (cur_dly != '0) begin
        n_dly = cur_dly - 1'b1;
      end else if (cur_reg[B_LOAD]) begin
        n_reg[B_LOAD] = 1'b0;
        if (st == ST_FETCH) begin
          n_reg = go_state(n_reg, ST_ERR);
          n_reg[B_FCE] = 1'b1;
        end else begin
          n_reg = go_state(go_state(n_reg, ST_SEND), ST_UNSET);
        end
      end else if (cur_reg[B_MOVE]) begin
        if (st == ST_WSYNC) begin
          n_reg = go_state(n_reg, ST_FETCH);
          n_dly = TW'(DLY);
        end else if (st == ST_FETCH) begin
          if (cur_sent) begin
            n_reg = go_state(n_reg, ST_RUN);
            n_reg[B_MOVE] = 1'b0;
            n_ready = 1'b0;
            n_sent = 1'b0;
          end
        end else begin
          n_reg = go_state(n_reg, ST_ERR);
          n_reg[B_FCE] = 1'b1;
          n_ready = 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/tbsync_ctrl.sv
module tbsync_ctrl
  import tbsync_pkg::*;
#(
  parameter int DELAY_READS = 3,
  parameter int SYNC_READS  = 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [63:0]     wr_data,
  input  logic            rd_en,
  output logic [63:0]     rd_data,
  input  logic            is_thread0,
  input  logic            tod_sent_pulse,
  output logic            ready_for_tod,
  output logic            tb_valid,
  output logic            ctl_error
);
  localparam int TW = $clog2(DELAY_READS + 1);
  localparam int SW = $clog2(SYNC_READS + 1);

  logic [XLEN-1:0] reg_q;
  logic            ready_q, sent_q;
  logic [TW-1:0]   dly_q;
  logic [SW-1:0]   syn_q;

  logic [XLEN-1:0] w_reg, r_reg;
  logic            w_ready, r_ready, w_sent, r_sent;
  logic [TW-1:0]   w_dly, r_dly;
  logic [SW-1:0]   w_syn, r_syn;

  tbsync_wr #(.TW(TW), .SW(SW), .DLY(DELAY_READS), .SYN(SYNC_READS)) wr_i (
    .cur_reg(reg_q), .cur_ready(ready_q), .cur_sent(sent_q), .cur_dly(dly_q), .cur_syn(syn_q),
    .wdata(wr_data), .is_t0(is_thread0),
    .n_reg(w_reg), .n_ready(w_ready), .n_sent(w_sent), .n_dly(w_dly), .n_syn(w_syn)
  );

  tbsync_rd #(.TW(TW), .SW(SW), .DLY(DELAY_READS)) rd_i (
    .cur_reg(reg_q), .cur_ready(ready_q), .cur_sent(sent_q), .cur_dly(dly_q), .cur_syn(syn_q),
    .n_reg(r_reg), .n_ready(r_ready), .n_sent(r_sent), .n_dly(r_dly), .n_syn(r_syn)
  );

  logic [XLEN-1:0] nx_reg;
  logic            nx_ready, nx_sent;
  logic [TW-1:0]   nx_dly;
  logic [SW-1:0]   nx_syn;

  always_comb begin
    nx_reg = reg_q; nx_ready = ready_q; nx_sent = sent_q; nx_dly = dly_q; nx_syn = syn_q;
    if (wr_en) begin
      nx_reg = w_reg; nx_ready = w_ready; nx_sent = w_sent; nx_dly = w_dly; nx_syn = w_syn;
    end else if (rd_en) begin
      nx_reg = r_reg; nx_ready = r_ready; nx_sent = r_sent; nx_dly = r_dly; nx_syn = r_syn;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_q   <= '0;
      ready_q <= 1'b0;
      sent_q  <= 1'b0;
      dly_q   <= '0;
      syn_q   <= '0;
      rd_data <= '0;
    end else begin
      reg_q   <= nx_reg;
      ready_q <= nx_ready;
      sent_q  <= nx_sent | (tod_sent_pulse & ready_q & nx_ready);
      dly_q   <= nx_dly;
      syn_q   <= nx_syn;
      if (rd_en && !wr_en) rd_data <= r_reg | (XLEN'(1) << B_MODE);
    end
  end

  assign ready_for_tod = ready_q;
  assign tb_valid      = reg_q[B_VALID];
  assign ctl_error     = reg_q[B_FCE];
endmodule

// File: rtl/tbsync_chk.sv
module tbsync_chk
  import tbsync_pkg::*;
(
  input logic        clk,
  input logic        rst,
  input logic        wr_en,
  input logic [63:0] wr_data,
  input logic        rd_en,
  input logic [63:0] rd_data,
  input logic        is_thread0,
  input logic        ctl_error,
  input logic [3:0]  cur_state
);
  AST_MODE_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_data[B_MODE]) |=> (cur_state == 4'd0)); // R2

  AST_READ_MODE_ONE: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !wr_en) |=> rd_data[B_MODE]); // R1

  AST_READ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!rd_en || wr_en) |=> $stable(rd_data)); // R13

  AST_ERR_READ_STUCK: assert property (@(posedge clk) disable iff (rst)
    (cur_state == 4'd9 && !wr_en) |=> (cur_state == 4'd9)); // R13

  AST_NON_T0_NO_STEP: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_data[B_MODE] && !is_thread0 && (wr_data[B_LOAD] || wr_data[B_MOVE]))
      |=> $stable(cur_state)); // R11

  AST_ERR_ENTRY_FLAG: assert property (@(posedge clk) disable iff (rst)
    (cur_state == 4'd9 && $past(cur_state) != 4'd9) |-> ctl_error); // R5
endmodule

bind tbsync_ctrl tbsync_chk chk_i (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
  .rd_data(rd_data), .is_thread0(is_thread0), .ctl_error(ctl_error),
  .cur_state(reg_q[35:32])
);

// File: tb/tbsync_ctrl_tb.sv
module tbsync_ctrl_tb_top;
  localparam int CLK_NS = 10;
  localparam logic [63:0] M  = 64'd1 << (63-14);
  localparam logic [63:0] LD = 64'd1 << (63-16);
  localparam logic [63:0] MV = 64'd1 << (63-18);
  localparam logic [63:0] CL = 64'd1 << (63-24);
  localparam logic [63:0] FE = 64'd1 << (63-46);
  localparam logic [63:0] CTRLM = {{25{1'b1}}, {39{1'b0}}};

  logic clk = 0, rst = 1, wr_en = 0, rd_en = 0, is_thread0 = 1, tod_sent_pulse = 0;
  logic [63:0] wr_data = '0, rd_data;
  logic ready_for_tod, tb_valid, ctl_error;
  int n_chk = 0, n_fail = 0;

  tbsync_ctrl dut_i (.*);
  always #(CLK_NS/2) clk = ~clk;

  // reference state
  logic [63:0] m_reg, m_rd;
  logic m_ready, m_sent;
  int m_dly, m_syn;

  function automatic logic [3:0] cur(logic [63:0] r); return r[35:32]; endfunction
  function automatic logic [63:0] mv(logic [63:0] r, logic [3:0] s);
    r[31:28] = r[35:32]; r[35:32] = s; r[63-41] = (s == 4'd8); return r;
  endfunction

  task automatic m_err(inout logic [63:0] r);
    r = mv(r, 4'd9); r[63-46] = 1'b1;
  endtask

  task automatic m_write(logic [63:0] v, bit t0);
    logic [63:0] t;
    t = (m_reg & ~CTRLM) | (v & CTRLM);
    t[63-46] = m_reg[63-46] & ~v[63-46];
    t[63-42] = 1'b0;
    if (!v[63-14]) begin m_reg[35:28] = '0; return; end
    if (cur(m_reg) == 4'd9 && !t[63-24] && !(t[63-16] && t[63-18]) &&
        (t0 || !(v[63-16] || v[63-18]))) begin
      m_reg[63-46] = 1'b1; return;
    end
    m_syn = 1;
    if (!t0 && (v[63-16] || v[63-18])) begin m_reg = t; return; end
    if (t[63-16] && t[63-18]) begin m_err(t); m_ready = 0; m_reg = t; return; end
    if (t[63-24]) begin
      t = mv(t, 4'd0); t[63-24] = 0; t[63-16] = 0; t[63-18] = 0; t[63-46] = 0;
      m_ready = 0; m_sent = 0; m_reg = t; return;
    end
    if (t[63-16]) m_dly = 3;
    else if (t[63-18]) begin
      if (cur(t) == 4'd2) begin t = mv(t, 4'd6); m_ready = 1; m_dly = 3; end
      else begin m_err(t); m_ready = 0; end
    end
    m_reg = t;
  endtask

  task automatic m_read();
    logic [63:0] t;
    t = m_reg;
    if (t[63-14] && cur(t) != 4'd9) begin
      if (m_syn != 0) m_syn--; else t[63-42] = 1'b1;
      if (m_dly != 0) m_dly--;
      else if (t[63-16]) begin
        t[63-16] = 0;
        if (cur(t) == 4'd7) m_err(t);
        else t = mv(mv(t, 4'd1), 4'd2);
      end else if (t[63-18]) begin
        if (cur(t) == 4'd6) begin t = mv(t, 4'd7); m_dly = 3; end
        else if (cur(t) == 4'd7) begin
          if (m_sent) begin t = mv(t, 4'd8); t[63-18] = 0; m_ready = 0; m_sent = 0; end
        end else begin m_err(t); m_ready = 0; end
      end
    end
    m_reg = t;
    m_rd = t | M;
  endtask

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic op(bit w, logic [63:0] v, bit t0, bit r, bit p, string tag);
    bit old_ready;
    @(negedge clk);
    wr_en = w; wr_data = v; is_thread0 = t0; rd_en = r; tod_sent_pulse = p;
    old_ready = m_ready;
    if (w) m_write(v, t0); else if (r) m_read();
    if (p && old_ready && m_ready) m_sent = 1;
    @(negedge clk);
    wr_en = 0; rd_en = 0; tod_sent_pulse = 0;
    chk({tag, " rd_data"}, rd_data, m_rd);
    chk({tag, " outputs"}, {61'd0, ready_for_tod, tb_valid, ctl_error},
        {61'd0, m_ready, m_reg[63-41], m_reg[63-46]});
  endtask

  task automatic rd(string tag, int n = 1);
    for (int i = 0; i < n; i++) op(0, '0, 1, 1, 0, tag);
  endtask

  initial begin
    #(CLK_NS * 190000);
    n_fail++; n_chk++;
    $display("FAIL watchdog act=running exp=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int seed;
    m_reg = '0; m_rd = '0; m_ready = 0; m_sent = 0; m_dly = 0; m_syn = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    chk("R14 reset rd_data", rd_data, 64'd0);
    chk("R14 reset outputs", {61'd0, ready_for_tod, tb_valid, ctl_error}, 64'd0);
    rd("R13 read with mode clear");
    op(1, M | (64'd1 << (63-10)), 1, 0, 0, "R1 write mode");
    rd("R1 R4 first read");
    rd("R4 sync set on second read");
    op(1, M | LD, 1, 0, 0, "R8 load write");
    rd("R8 delay", 3);
    rd("R8 R3 to unset");
    op(1, M | MV, 1, 0, 1, "R9 R12 move write, early pulse");
    rd("R10 wait-sync delay", 4);
    rd("R10 fetch delay", 4);
    rd("R12 no sent flag yet", 2);
    op(0, '0, 1, 1, 1, "R12 pulse with read");
    rd("R10 R3 to running");
    op(1, M | MV, 1, 0, 0, "R9 move outside unset");
    op(1, M | FE, 1, 0, 0, "R7 write in error");
    rd("R13 read in error");
    op(1, M | CL, 1, 0, 1, "R6 clear errors");
    rd("R6 after clear");
    op(1, M | LD | MV, 1, 0, 0, "R5 both requests");
    rd("R5 after error");
    op(1, M | CL, 1, 0, 0, "R6 clear again");
    op(1, M | LD, 0, 0, 0, "R11 load from other thread");
    rd("R11 no delay armed");
    op(1, M | MV, 1, 1, 0, "R13 write and read together");
    rd("R13 read after coincident", 8);
    op(1, M | LD, 1, 0, 0, "R10 load in fetch");
    rd("R10 load in fetch to error", 4);
    op(1, 64'h0, 1, 0, 0, "R2 mode clear write");
    rd("R2 R13 read after mode clear");
    op(1, M | CL, 1, 0, 0, "R6 restart");
    seed = 17;
    void'($urandom(seed));
    for (int i = 0; i < 600; i++) begin
      logic [63:0] v;
      int k;
      k = $urandom_range(0, 9);
      v = M | ({$urandom, $urandom} & CTRLM & ~(LD | MV | CL));
      if ($urandom_range(0, 3) == 0) v = v | LD;
      if ($urandom_range(0, 2) == 0) v = v | MV;
      if ($urandom_range(0, 7) == 0) v = v | CL;
      if ($urandom_range(0, 5) == 0) v = v | FE;
      if ($urandom_range(0, 15) == 0) v = v & ~M;
      if (k < 6) op(0, '0, 1, 1, $urandom_range(0, 3) == 0, "R10 random read");
      else op(1, v, $urandom_range(0, 4) != 0, k == 9, $urandom_range(0, 3) == 0,
              "R12 random write");
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule